// File: doc/BRIEF.md
# Strided Vector Memory Address Generator

This block turns a single vector load or store into a sequence of word accesses against a word-interleaved memory of sixteen banks. When started it latches a base word address, a stride and an element count. It then produces the address of each element in turn as base plus index times stride. The low bits of each address pick the bank. At most one access is started per cycle, and each bank stays occupied for a fixed number of cycles after an access.

A countdown for each bank records how long that bank remains occupied. When the next element falls on a bank that is still occupied, issue waits. Elements are never reordered. Store data is taken from a valid/ready pair, one word per issued element and in element order. Load data comes back after the bank latency, in element order and tagged with its element index. A one-cycle done pulse marks the completion of the last element.

A small behavioural word memory sits inside the block so that the access stream can be observed end to end. There is one address generator and one memory port, so a new vector is accepted only when the previous one has fully drained.

Top module: `vec_agu`

## Requirements
- R1: The address of element i is (base + i*stride) modulo 2^ADDR_W, and accesses appear in increasing element order with acc_idx equal to i. The stride value 255 therefore walks downward.
- R2: The bank of each access (acc_bank) is the low four bits of its word address.
- R3: At most one access is started per cycle. When no bank conflict exists, element 0 is issued in the cycle after start is sampled and each later element follows in the next cycle.
- R4: An access occupies its bank for 11 cycles. An element whose bank is occupied waits, so two accesses to one bank are at least 11 cycles apart, and no other element overtakes the waiting one.
- R5: Load data for an element issued in cycle t is presented on ld_valid/ld_data/ld_idx in cycle t+10, with the element's index. Loads are returned in order.
- R6: A store element is issued only in a cycle where st_valid and st_ready are both high, and it consumes st_data. A later load of the same address returns that word.
- R7: done is high for one cycle, in the cycle the last element completes. For a load this is the cycle its last data word is presented.
- R8: A vector length of 0 raises done in the cycle after start is sampled and starts no access.
- R9: start is ignored while busy is high, and the vector in progress continues unchanged.
- R10: After reset, busy, acc_valid, ld_valid and done are low.
- R11: A vector length above MAX_VLEN (32) is handled as MAX_VLEN elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a vector operation; sampled only when busy is low |
| op_store | input | 1 | 1 = store vector, 0 = load vector |
| base | input | ADDR_W | Word address of element 0 |
| stride | input | ADDR_W | Word distance between elements (modulo arithmetic) |
| vlen | input | LEN_W | Element count, saturated at MAX_VLEN |
| busy | output | 1 | Vector issuing or accesses still in flight |
| st_valid | input | 1 | Store word offered |
| st_data | input | DATA_W | Store word for the next element |
| st_ready | output | 1 | Next store element can be issued this cycle |
| acc_valid | output | 1 | A bank access starts this cycle |
| acc_write | output | 1 | The access is a write |
| acc_addr | output | ADDR_W | Word address of the access |
| acc_bank | output | BANK_W | Bank of the access |
| acc_idx | output | IDX_W | Element index of the access |
| ld_valid | output | 1 | Load word returned |
| ld_idx | output | IDX_W | Element index of the returned word |
| ld_data | output | DATA_W | Returned word |
| done | output | 1 | Last element of the vector completed |

## Verification
For each vector, the bench replays the bank occupancy rule on its own to find the cycle t in which every element should issue. The access is due on the ports during cycle t, its load word in cycle t+10, and done together with the last word, or in the first cycle after start for an empty vector. Every expectation carries its due cycle, and the monitor samples on the falling edge against a cycle count. An output that arrives early, late, missing or extra is therefore a mismatch, not a tolerated delay. Stores are checked both by the cycle of their issue and by reloading the written words.

// File: rtl/vagu_pkg.sv
`timescale 1ns/1ps
// Shared types for the strided vector address generator.
package vagu_pkg;
    typedef enum logic { OP_LOAD = 1'b0, OP_STORE = 1'b1 } vagu_op_e;
endpackage

// File: rtl/vagu_issue.sv
`timescale 1ns/1ps
// Element sequencer: latches base/stride/length on an accepted start and
// walks the element addresses in order, issuing one whenever the target
// bank is free (and, for stores, a data word is offered).
// Assumes start_ok is only asserted while the whole block is idle.
module vagu_issue #(
    parameter int ADDR_W   = 8,
    parameter int NUM_BANKS = 16,
    parameter int MAX_VLEN = 32,
    localparam int BANK_W  = $clog2(NUM_BANKS),
    localparam int IDX_W   = $clog2(MAX_VLEN),
    localparam int LEN_W   = $clog2(MAX_VLEN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_ok,
    input  logic                 op_store,
    input  logic [ADDR_W-1:0]    base,
    input  logic [ADDR_W-1:0]    stride,
    input  logic [LEN_W-1:0]     vlen,
    input  logic [NUM_BANKS-1:0] bank_free,
    input  logic                 st_valid,
    output logic                 active,
    output logic                 st_ready,
    output logic                 issue,
    output logic                 issue_write,
    output logic [ADDR_W-1:0]    issue_addr,
    output logic [BANK_W-1:0]    issue_bank,
    output logic [IDX_W-1:0]     issue_idx,
    output logic                 issue_last,
    output logic                 zero_done
);
    import vagu_pkg::*;

    vagu_op_e            op_r;
    logic [ADDR_W-1:0]   stride_r;
    logic [ADDR_W-1:0]   addr_r;
    logic [IDX_W-1:0]    idx_r;
    logic [IDX_W-1:0]    last_idx_r;
    logic [LEN_W-1:0]    eff_len;
    logic                can_go;

    // Saturate the requested length at the register capacity.
    always_comb eff_len = (vlen > LEN_W'(MAX_VLEN)) ? LEN_W'(MAX_VLEN) : vlen;

    // Issue decision for the current element.
    always_comb begin
        issue_bank  = addr_r[BANK_W-1:0];
        can_go      = active && bank_free[issue_bank];
        st_ready    = can_go && (op_r == OP_STORE);
        issue       = can_go && ((op_r == OP_LOAD) || st_valid);
        issue_write = (op_r == OP_STORE);
        issue_addr  = addr_r;
        issue_idx   = idx_r;
        issue_last  = (idx_r == last_idx_r);
    end

    // Sequencer state: load on start, advance on each issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            op_r       <= OP_LOAD;
            stride_r   <= '0;
            addr_r     <= '0;
            idx_r      <= '0;
            last_idx_r <= '0;
            zero_done  <= 1'b0;
        end else begin
            zero_done <= 1'b0;
            if (start_ok) begin
                op_r       <= op_store ? OP_STORE : OP_LOAD;
                stride_r   <= stride;
                addr_r     <= base;
                idx_r      <= '0;
                last_idx_r <= IDX_W'(eff_len - LEN_W'(1));
                if (eff_len == '0) zero_done <= 1'b1;
                else               active    <= 1'b1;
            end else if (issue) begin
                addr_r <= addr_r + stride_r;
                idx_r  <= idx_r + IDX_W'(1);
                if (issue_last) active <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/vagu_bank_timers.sv
`timescale 1ns/1ps
// One occupancy countdown per bank. An access loads BANK_LAT-1, so the
// bank reads free again BANK_LAT cycles after the issuing cycle.
// Assumes BANK_LAT >= 2.
module vagu_bank_timers #(
    parameter int NUM_BANKS = 16,
    parameter int BANK_LAT  = 11,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int CNT_W    = $clog2(BANK_LAT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue,
    input  logic [BANK_W-1:0]    issue_bank,
    output logic [NUM_BANKS-1:0] bank_free
);
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [CNT_W-1:0] cnt;
        // Reload on an access to this bank, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt <= '0;
            else if (issue && (issue_bank == BANK_W'(g)))
                cnt <= CNT_W'(BANK_LAT - 1);
            else if (cnt != '0)
                cnt <= cnt - CNT_W'(1);
        end
        assign bank_free[g] = (cnt == '0);
    end
endmodule

// File: rtl/vagu_mem_model.sv
`timescale 1ns/1ps
// Behavioural word memory plus a fixed-latency completion pipe.
// Writes land at issue; reads are captured at issue and delayed so that
// every access completes BANK_LAT-1 cycles after its issue cycle.
module vagu_mem_model #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int MAX_VLEN = 32,
    parameter int BANK_LAT = 11,
    localparam int IDX_W     = $clog2(MAX_VLEN),
    localparam int MEM_WORDS = 1 << ADDR_W,
    localparam int DEPTH     = BANK_LAT - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              issue_write,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic [IDX_W-1:0]  issue_idx,
    input  logic              issue_last,
    input  logic [DATA_W-1:0] st_data,
    output logic              ld_valid,
    output logic [IDX_W-1:0]  ld_idx,
    output logic [DATA_W-1:0] ld_data,
    output logic              cmp_last,
    output logic              inflight
);
    typedef struct packed {
        logic              vld;
        logic              wr;
        logic              last;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } slot_t;

    logic [DATA_W-1:0] mem [MEM_WORDS];
    slot_t             pipe [DEPTH];

    // Storage array: write the offered word when a store issues.
    always_ff @(posedge clk) begin
        if (issue && issue_write) mem[issue_addr] <= st_data;
    end

    // Completion pipe: capture at issue, shift one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= '{issue, issue_write, issue_last, issue_idx, mem[issue_addr]};
            for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
        end
    end

    // Output stage and in-flight summary.
    always_comb begin
        ld_valid = pipe[DEPTH-1].vld && !pipe[DEPTH-1].wr;
        ld_idx   = pipe[DEPTH-1].idx;
        ld_data  = pipe[DEPTH-1].data;
        cmp_last = pipe[DEPTH-1].vld && pipe[DEPTH-1].last;
        inflight = 1'b0;
        for (int i = 0; i < DEPTH; i++) inflight = inflight | pipe[i].vld;
    end
endmodule

// File: rtl/vec_agu.sv
`timescale 1ns/1ps
// Strided vector memory address generator for a word-interleaved,
// multi-bank memory. Accepts a vector only when fully idle (one port,
// one generator); issues elements in order, stalling on busy banks.
module vec_agu #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int NUM_BANKS = 16,
    parameter int BANK_LAT  = 11,
    parameter int MAX_VLEN  = 32,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int IDX_W    = $clog2(MAX_VLEN),
    localparam int LEN_W    = $clog2(MAX_VLEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_store,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [LEN_W-1:0]  vlen,
    output logic              busy,
    input  logic              st_valid,
    input  logic [DATA_W-1:0] st_data,
    output logic              st_ready,
    output logic              acc_valid,
    output logic              acc_write,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [BANK_W-1:0] acc_bank,
    output logic [IDX_W-1:0]  acc_idx,
    output logic              ld_valid,
    output logic [IDX_W-1:0]  ld_idx,
    output logic [DATA_W-1:0] ld_data,
    output logic              done
);
    logic                 active, inflight, start_ok, issue_last;
    logic                 zero_done, cmp_last;
    logic [NUM_BANKS-1:0] bank_free;

    // Accept a new vector only when nothing is issuing or in flight.
    always_comb begin
        busy     = active || inflight;
        start_ok = start && !busy;
        done     = cmp_last || zero_done;
    end

    vagu_issue #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .MAX_VLEN(MAX_VLEN)) u_issue (
        .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .op_store(op_store),
        .base(base), .stride(stride), .vlen(vlen), .bank_free(bank_free),
        .st_valid(st_valid), .active(active), .st_ready(st_ready),
        .issue(acc_valid), .issue_write(acc_write), .issue_addr(acc_addr),
        .issue_bank(acc_bank), .issue_idx(acc_idx), .issue_last(issue_last),
        .zero_done(zero_done)
    );

    vagu_bank_timers #(.NUM_BANKS(NUM_BANKS), .BANK_LAT(BANK_LAT)) u_timers (
        .clk(clk), .rst_n(rst_n), .issue(acc_valid), .issue_bank(acc_bank),
        .bank_free(bank_free)
    );

    vagu_mem_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_VLEN(MAX_VLEN),
                     .BANK_LAT(BANK_LAT)) u_mem (
        .clk(clk), .rst_n(rst_n), .issue(acc_valid), .issue_write(acc_write),
        .issue_addr(acc_addr), .issue_idx(acc_idx), .issue_last(issue_last),
        .st_data(st_data), .ld_valid(ld_valid), .ld_idx(ld_idx),
        .ld_data(ld_data), .cmp_last(cmp_last), .inflight(inflight)
    );
endmodule

// File: rtl/vec_agu_chk.sv
`timescale 1ns/1ps
// Protocol checker for vec_agu, attached by bind below. Observes ports only.
module vec_agu_chk #(
    parameter int BANK_W = 4,
    parameter int IDX_W  = 5,
    parameter int LEN_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [LEN_W-1:0]  vlen,
    input logic              busy,
    input logic              st_valid,
    input logic              st_ready,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [BANK_W-1:0] acc_bank,
    input logic              ld_valid,
    input logic [IDX_W-1:0]  ld_idx,
    input logic              done
);
    logic [IDX_W-1:0] next_ld;

    // Tracks the element index the next returned load word must carry.
    always_ff @(posedge clk) begin
        if (!rst_n)        next_ld <= '0;
        else if (ld_valid) next_ld <= done ? '0 : ld_idx + IDX_W'(1);
    end

    assert_bank_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> !(acc_valid && (acc_bank == $past(acc_bank))));

    assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (vlen == '0)) |=> (done && !acc_valid));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!acc_valid && !ld_valid));

    assert_store_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write) |-> (st_valid && st_ready));

    assert_load_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> (ld_idx == next_ld));
endmodule

bind vec_agu vec_agu_chk #(.BANK_W(BANK_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen), .busy(busy),
    .st_valid(st_valid), .st_ready(st_ready), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_bank(acc_bank), .ld_valid(ld_valid),
    .ld_idx(ld_idx), .done(done)
);

// File: tb/vec_agu_tb_top.sv
`timescale 1ns/1ps
module vec_agu_tb_top;
    localparam int AW = 8, DW = 16, LAT = 11, MAXV = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          start = 0, op_store = 0, st_valid = 0;
    logic [AW-1:0] base = 0, stride = 0;
    logic [5:0]    vlen = 0;
    logic [DW-1:0] st_data = 0;
    logic          busy, st_ready, acc_valid, acc_write, ld_valid, done;
    logic [AW-1:0] acc_addr;
    logic [3:0]    acc_bank;
    logic [4:0]    acc_idx, ld_idx;
    logic [DW-1:0] ld_data;

    vec_agu #(.ADDR_W(AW), .DATA_W(DW), .NUM_BANKS(16), .BANK_LAT(LAT), .MAX_VLEN(MAXV)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_store(op_store), .base(base),
        .stride(stride), .vlen(vlen), .busy(busy), .st_valid(st_valid), .st_data(st_data),
        .st_ready(st_ready), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_bank(acc_bank), .acc_idx(acc_idx),
        .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_data(ld_data), .done(done)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_cmp = 0, n_bad = 0;
    typedef struct { int idx; int addr; int wr; int at; string tag; } acc_t;
    typedef struct { int idx; int data; int at; string tag; } ld_t;
    typedef struct { int at; string tag; } dn_t;
    acc_t acc_q[$];
    ld_t  ld_q[$];
    dn_t  dn_q[$];
    int   exp_mem [256];

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Monitor: pops the scoreboard as results appear, checking cycle of arrival.
    always @(negedge clk) begin
        acc_t a; ld_t l; dn_t d;
        if (rst_n) begin
            if (acc_valid) begin
                if (acc_q.size() == 0) chk(0, "R3", "unexpected access idx", int'(acc_idx), -1);
                else begin
                    a = acc_q.pop_front();
                    chk(int'(acc_idx) == a.idx, a.tag, "access index", int'(acc_idx), a.idx);
                    chk(int'(acc_addr) == a.addr, "R1", "access address", int'(acc_addr), a.addr);
                    chk(int'(acc_bank) == (a.addr & 15), "R2", "access bank", int'(acc_bank), a.addr & 15);
                    chk(int'(acc_write) == a.wr, a.tag, "access write flag", int'(acc_write), a.wr);
                    chk(cyc == a.at, a.tag, "access cycle", cyc, a.at);
                end
            end else if (acc_q.size() > 0 && acc_q[0].at <= cyc) begin
                a = acc_q.pop_front();
                chk(0, a.tag, "missing access, cycle", cyc, a.at);
            end
            if (ld_valid) begin
                if (ld_q.size() == 0) chk(0, "R5", "unexpected load idx", int'(ld_idx), -1);
                else begin
                    l = ld_q.pop_front();
                    chk(int'(ld_idx) == l.idx, "R5", "load index", int'(ld_idx), l.idx);
                    chk(int'(ld_data) == l.data, l.tag, "load data", int'(ld_data), l.data);
                    chk(cyc == l.at, "R5", "load cycle", cyc, l.at);
                end
            end else if (ld_q.size() > 0 && ld_q[0].at <= cyc) begin
                l = ld_q.pop_front();
                chk(0, "R5", "missing load, cycle", cyc, l.at);
            end
            if (done) begin
                if (dn_q.size() == 0) chk(0, "R7", "unexpected done", cyc, -1);
                else begin
                    d = dn_q.pop_front();
                    chk(cyc == d.at, d.tag, "done cycle", cyc, d.at);
                end
            end else if (dn_q.size() > 0 && dn_q[0].at <= cyc) begin
                d = dn_q.pop_front();
                chk(0, d.tag, "missing done, cycle", cyc, d.at);
            end
        end
    end

    function automatic int fill_val(input int a);
        return (a * 97 + 'h1234) & 'hFFFF;
    endfunction

    // Driver: models bank occupancy, queues expectations, then drives the vector.
    task automatic run_vec(input string tag, input bit wr, input int b, input int s,
                           input int n, input int hold, input bit poke, input int dbase);
        int fr[16];
        int sd[32];
        int prev, e, sc, nn, a, k, c;
        bit consumed;
        @(negedge clk);
        sc = cyc + 1;
        nn = (n > MAXV) ? MAXV : n;
        foreach (fr[i]) fr[i] = 0;
        prev = sc;
        for (int i = 0; i < nn; i++) begin
            a = (b + i * s) & 255;
            e = prev + 1;
            if (fr[a & 15] > e) e = fr[a & 15];
            if (wr && e < sc + 1 + hold) e = sc + 1 + hold;
            fr[a & 15] = e + LAT;
            prev = e;
            acc_q.push_back('{i, a, int'(wr), e - 1, tag});
            if (wr) begin
                sd[i] = (dbase < 0) ? fill_val(a) : ((dbase + i) & 'hFFFF);
                exp_mem[a] = sd[i];
            end else begin
                ld_q.push_back('{i, exp_mem[a], e + LAT - 2, tag});
            end
        end
        dn_q.push_back('{(nn > 0) ? prev + LAT - 2 : sc, (nn > 0) ? "R7" : "R8"});
        start = 1; op_store = wr; base = AW'(b); stride = AW'(s); vlen = 6'(n);
        @(negedge clk);
        start = 0;
        c = 0; k = 0;
        if (wr) begin
            while (k < nn) begin
                if (c >= hold) begin st_valid = 1; st_data = DW'(sd[k]); end
                consumed = st_valid && st_ready;
                @(negedge clk);
                c++;
                if (consumed) k++;
            end
            st_valid = 0;
        end
        while (busy) begin
            if (poke && c == 3) begin
                start = 1; op_store = 1; base = 8'd200; stride = 8'd16; vlen = 6'd5;
            end else start = 0;
            @(negedge clk);
            c++;
        end
        start = 0;
        @(negedge clk);
        chk(acc_q.size() == 0 && ld_q.size() == 0 && dn_q.size() == 0, (tag == "R9") ? "R9" : "R7",
            "expectations left after drain", acc_q.size() + ld_q.size() + dn_q.size(), 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R3 watchdog: actual timeout expected completion (cycle %0d)", cyc);
        summary();
        $finish;
    end

    initial begin
        foreach (exp_mem[i]) exp_mem[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: quiet after reset
        chk(busy == 0, "R10", "busy after reset", int'(busy), 0);
        chk(acc_valid == 0, "R10", "acc_valid after reset", int'(acc_valid), 0);
        chk(ld_valid == 0, "R10", "ld_valid after reset", int'(ld_valid), 0);
        chk(done == 0, "R10", "done after reset", int'(done), 0);

        // R6: fill memory with stride-1 stores
        for (int v = 0; v < 8; v++) run_vec("R6", 1, v * 32, 1, 32, 0, 0, -1);
        run_vec("R3", 0, 5, 1, 20, 0, 0, 0);     // R3: back-to-back, no conflict
        run_vec("R3", 0, 250, 3, 32, 0, 0, 0);   // R3/R1: odd stride wraps
        run_vec("R4", 0, 7, 16, 4, 0, 0, 0);     // R4: one bank, 11 apart
        run_vec("R4", 0, 0, 2, 12, 0, 0, 0);     // R4: eight banks, stall at element 8
        run_vec("R1", 0, 3, 255, 10, 0, 0, 0);   // R1: downward stride
        run_vec("R8", 0, 9, 1, 0, 0, 0, 0);      // R8: empty vector
        run_vec("R9", 0, 40, 1, 16, 0, 1, 0);    // R9: start while busy
        run_vec("R6", 1, 100, 5, 6, 4, 0, 'hC000); // R6: store waits for st_valid
        run_vec("R6", 0, 100, 5, 6, 0, 0, 0);    // R6: read back
        run_vec("R11", 0, 0, 7, 40, 0, 0, 0);    // R11: length saturates at 32
        summary();
        $finish;
    end
endmodule